// File: doc/BRIEF.md
# Hamming-Guarded FIR Output Stage

This block is a four-tap direct-form FIR filter. Its 16-bit result is carried through a single-error-correcting Hamming stage before it leaves the block. Each accepted input sample is multiplied against the three samples before it using four programmable coefficients. The sum is kept at full precision and then clamped to the signed 16-bit range. The clamped word is expanded into a 21-bit codeword with five check bits.

An injection mask is XORed onto the codeword as it is formed, so faults can be planted inside the block. A decoder then recomputes the checks into a five-bit syndrome. It flips the bit the syndrome names and extracts the 16 data bits again. The corrected word, the raw syndrome and an error flag are presented together with a valid strobe. Errors of more than one bit are not detected separately and may be miscorrected without warning.

Top module: `ham_guarded_fir`

## Requirements
- R1: A synchronous active-low reset drives `out_valid`, `out_result`, `out_syndrome` and `out_err` to zero and empties the sample history. The first sample after reset is therefore filtered against zero history.
- R2: For each sample accepted while `in_valid` is high, the result is y(n) = sum over k=0..3 of h(k)·x(n−k). h(k) is `coef[16k+15:16k]` taken as signed. x(n) is the sample being accepted and x(n−k) is the k-th earlier accepted sample. Cycles with `in_valid` low do not advance the history.
- R3: The sum is formed at full precision and then clamped to the range −32768..32767.
- R4: A sample accepted at clock edge N is presented after edge N+1. `out_valid` is high for exactly one cycle for each accepted sample, with no gaps inserted between back-to-back samples.
- R5: While `out_valid` is low, `out_result`, `out_syndrome` and `out_err` keep their last values.
- R6: Codeword position p (1..21) is `inj_mask[p-1]`. Check bits sit at positions 1, 2, 4, 8 and 16. Data bit 0 sits at position 3, and the following data bits fill the remaining positions in ascending order. The mask applied to a result is the value of `inj_mask` at edge N+1.
- R7: With a zero mask, `out_syndrome` is 0, `out_err` is 0, and `out_result` equals the filter result.
- R8: With exactly one mask bit set at position p, `out_syndrome` equals p, with the position-16 check at bit 4 and the position-1 check at bit 0. `out_err` is 1 and `out_result` equals the filter result. This holds for check positions as well as data positions. Position 14, for example, gives 01110.
- R9: A syndrome of 22 to 31 names no position. No bit is flipped, `out_err` is 1, and the data is extracted from the faulty codeword unchanged.
- R10: A multi-bit fault whose syndrome falls in 1..21 flips the named position and raises `out_err`, producing the miscorrected word with no separate indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| coef | input | 64 | Four signed 16-bit coefficients, tap k at bits 16k+15:16k |
| inj_mask | input | 21 | Fault mask XORed onto the codeword |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | Corrected signed result |
| out_syndrome | output | 5 | Recomputed syndrome |
| out_err | output | 1 | Syndrome nonzero |

## Verification
Clamping and correction can act on the same word. A clamped extreme result can meet a planted flip on its sign bit or on a check bit in the decoder's cycle, while the next sample is being accepted at that same edge. The bench provokes this by sweeping a single flipped position over all 21 places with back-to-back samples and coefficients chosen so that many sums overflow. The bench's reference model computes the clamped value, encodes it, applies the mask, decodes it and compares the result on every clock. A wrong clamp, a wrong bit placement or a lost strobe shows up as a mismatch on that cycle.

// File: rtl/hfir_pkg.sv
// Shared helpers for the Hamming-guarded FIR.
// Assumes codewords of at most 63 bits.
package hfir_pkg;

    // Smallest number of check bits p with 2^p >= data width + p + 1.
    function automatic int ecc_par_bits(input int dw);
        int p;
        p = 0;
        for (int k = 1; k <= 6; k++) begin
            if (p == 0 && (1 << k) >= dw + k + 1) p = k;
        end
        return p;
    endfunction

    // Bit p-1 is set for every 1-based position p whose index has bit j set.
    function automatic logic [63:0] cover_bits(input int j);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p < 64; p++) begin
            if (((p >> j) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hfir_taps.sv
// Four-tap (TAPS) direct-form filter with full-precision sum, clamp to OUT_W,
// and one register stage. Tap 0 multiplies the sample being accepted.
// Assumes TAPS >= 2. History advances only on accepted samples.
module hfir_taps #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 4,
    parameter int OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    input  logic [TAPS*COEF_W-1:0]   coef,
    output logic signed [OUT_W-1:0]  y_q,
    output logic                     y_vld
);
    localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS);
    localparam logic signed [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] MIN_OUT = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(MAX_OUT);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(MIN_OUT);

    logic signed [IN_W-1:0]  hist [TAPS-1];
    logic signed [ACC_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [OUT_W-1:0] y_next;

    // One product per tap, operands sign-extended to the sum width.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic signed [IN_W-1:0]   xk;
        logic signed [COEF_W-1:0] hk;
        logic signed [ACC_W-1:0]  xe;
        logic signed [ACC_W-1:0]  he;
        if (k == 0) begin : g_new
            assign xk = in_sample;
        end else begin : g_old
            assign xk = hist[k-1];
        end
        assign hk      = coef[k*COEF_W +: COEF_W];
        assign xe      = ACC_W'(xk);
        assign he      = ACC_W'(hk);
        assign prod[k] = xe * he;
    end

    // Full-precision sum of all tap products.
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
    end

    // Clamp the sum to the signed output range.
    always_comb begin
        if (acc > SAT_HI)      y_next = MAX_OUT;
        else if (acc < SAT_LO) y_next = MIN_OUT;
        else                   y_next = acc[OUT_W-1:0];
    end

    // Register the result and shift the sample history on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q   <= '0;
            y_vld <= 1'b0;
            for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
        end else begin
            y_vld <= in_valid;
            if (in_valid) begin
                y_q     <= y_next;
                hist[0] <= in_sample;
                for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
            end
        end
    end

    // R4
    stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> y_vld);

    // R5
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_q));

    // R3
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc > SAT_HI) |=> (y_q == MAX_OUT));

    // R3
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc < SAT_LO) |=> (y_q == MIN_OUT));
endmodule

// File: rtl/hfir_encoder.sv
// Combinational Hamming encoder with fault injection. Check bits sit at the
// power-of-two positions (1-based); data fills the others in ascending order.
// The mask is XORed onto the finished codeword in the same cycle.
module hfir_encoder #(
    parameter int DATA_W = 16,
    parameter int PAR_W  = hfir_pkg::ecc_par_bits(DATA_W),
    parameter int CODE_W = DATA_W + PAR_W
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CODE_W-1:0] inj_mask,
    output logic [CODE_W-1:0] codeword
);
    logic [CODE_W-1:0] dplace;
    logic [CODE_W-1:0] base;
    logic [PAR_W-1:0]  par;

    // Place data bits and check bits at their codeword positions.
    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if ((p & (p - 1)) == 0) begin : g_chk
            assign dplace[p-1] = 1'b0;
            assign base[p-1]   = par[$clog2(p)];
        end else begin : g_dat
            assign dplace[p-1] = data_in[p - $clog2(p + 1) - 1];
            assign base[p-1]   = data_in[p - $clog2(p + 1) - 1];
        end
    end

    // Each check bit makes the parity of its covered group even.
    for (genvar j = 0; j < PAR_W; j++) begin : g_par
        localparam logic [CODE_W-1:0] COVER = CODE_W'(hfir_pkg::cover_bits(j));
        assign par[j] = ^(dplace & COVER);
    end

    assign codeword = base ^ inj_mask;
endmodule

// File: rtl/hfir_decoder.sv
// Hamming decoder with an output register. It recomputes the syndrome, flips the
// named position when it lies inside the codeword, extracts the data, and loads
// the outputs only when the incoming word is valid.
module hfir_decoder #(
    parameter int DATA_W = 16,
    parameter int PAR_W  = hfir_pkg::ecc_par_bits(DATA_W),
    parameter int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_vld,
    input  logic [CODE_W-1:0] cw_in,
    output logic              vld_q,
    output logic [DATA_W-1:0] data_q,
    output logic [PAR_W-1:0]  synd_q,
    output logic              err_q
);
    logic [PAR_W-1:0]  synd;
    logic [CODE_W-1:0] fixed;
    logic [DATA_W-1:0] dec_data;
    logic [DATA_W-1:0] raw_data;

    // Syndrome bit j is the parity of group j, including its check bit.
    for (genvar j = 0; j < PAR_W; j++) begin : g_syn
        localparam logic [CODE_W-1:0] COVER = CODE_W'(hfir_pkg::cover_bits(j));
        assign synd[j] = ^(cw_in & COVER);
    end

    // Flip the position the syndrome names, then pull out the data bits.
    for (genvar p = 1; p <= CODE_W; p++) begin : g_fix
        assign fixed[p-1] = cw_in[p-1] ^ (synd == PAR_W'(p));
        if ((p & (p - 1)) != 0) begin : g_dat
            assign dec_data[p - $clog2(p + 1) - 1] = fixed[p-1];
            assign raw_data[p - $clog2(p + 1) - 1] = cw_in[p-1];
        end
    end

    // Output register: load on valid words, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
            synd_q <= '0;
            err_q  <= 1'b0;
        end else begin
            vld_q <= cw_vld;
            if (cw_vld) begin
                data_q <= dec_data;
                synd_q <= synd;
                err_q  <= |synd;
            end
        end
    end

    // R9
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_vld && synd > PAR_W'(CODE_W)) |=> (data_q == $past(raw_data) && err_q));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_vld |=> ($stable(data_q) && $stable(synd_q) && $stable(err_q)));
endmodule

// File: rtl/ham_guarded_fir.sv
// Top: FIR taps -> register -> Hamming encode + fault mask -> decode -> register.
// Two register stages from sample to corrected output.
module ham_guarded_fir #(
    parameter int IN_W    = 16,
    parameter int COEF_W  = 16,
    parameter int TAPS    = 4,
    parameter int OUT_W   = 16,
    localparam int PAR_W  = hfir_pkg::ecc_par_bits(OUT_W),
    localparam int CODE_W = OUT_W + PAR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    input  logic [TAPS*COEF_W-1:0]   coef,
    input  logic [CODE_W-1:0]        inj_mask,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_result,
    output logic [PAR_W-1:0]         out_syndrome,
    output logic                     out_err
);
    logic signed [OUT_W-1:0] y_q;
    logic                    y_vld;
    logic [CODE_W-1:0]       codeword;
    logic [OUT_W-1:0]        data_q;

    hfir_taps #(
        .IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .OUT_W(OUT_W)
    ) u_taps (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coef(coef), .y_q(y_q), .y_vld(y_vld)
    );

    hfir_encoder #(
        .DATA_W(OUT_W), .PAR_W(PAR_W), .CODE_W(CODE_W)
    ) u_enc (
        .data_in(y_q), .inj_mask(inj_mask), .codeword(codeword)
    );

    hfir_decoder #(
        .DATA_W(OUT_W), .PAR_W(PAR_W), .CODE_W(CODE_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cw_vld(y_vld), .cw_in(codeword),
        .vld_q(out_valid), .data_q(data_q), .synd_q(out_syndrome), .err_q(out_err)
    );

    assign out_result = $signed(data_q);

    // R4
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |=> out_valid);

    // R4
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_vld |=> !out_valid);

    // R7
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && inj_mask == '0) |=>
            (out_result == $past(y_q) && !out_err && out_syndrome == '0));

    // R8
    single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && $countones(inj_mask) == 1) |=> (out_result == $past(y_q) && out_err));
endmodule

// File: tb/ham_guarded_fir_test.sv
module ham_guarded_fir_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic [63:0] coef = '0;
    logic [20:0] inj_mask = '0;
    logic out_valid;
    logic signed [15:0] out_result;
    logic [4:0] out_syndrome;
    logic out_err;

    always #4 clk = ~clk;

    ham_guarded_fir uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coef(coef), .inj_mask(inj_mask), .out_valid(out_valid),
        .out_result(out_result), .out_syndrome(out_syndrome), .out_err(out_err)
    );

    int checks = 0;
    int errors = 0;
    int hist[$];
    int coefv[4] = '{0, 0, 0, 0};
    bit s1_v = 0;
    int s1_y = 0;
    string s1_tag = "R1";
    bit e_v = 0;
    int e_data = 0;
    int e_synd = 0;
    bit e_flag = 0;
    string e_tag = "R1";
    logic [20:0] next_mask = '0;
    int seed = 12345;

    function automatic int rnd16();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) % 65536) - 32768;
    endfunction

    function automatic logic [20:0] ref_encode(input logic [15:0] d);
        logic [20:0] cw = '0;
        int di = 0;
        int s = 0;
        for (int p = 1; p <= 21; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p-1] = d[di];
                if (d[di]) s = s ^ p;
                di++;
            end
        end
        for (int j = 0; j < 5; j++) cw[(1 << j) - 1] = s[j];
        return cw;
    endfunction

    function automatic void ref_decode(input logic [20:0] cw, output int data, output int synd);
        int di = 0;
        synd = 0;
        data = 0;
        for (int p = 1; p <= 21; p++) if (cw[p-1]) synd = synd ^ p;
        if (synd >= 1 && synd <= 21) cw[synd-1] = ~cw[synd-1];
        for (int p = 1; p <= 21; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cw[p-1]) data = data | (1 << di);
                di++;
            end
        end
    endfunction

    function automatic int model_fir();
        longint acc = 0;
        for (int k = 0; k < hist.size(); k++) acc += longint'(hist[k]) * longint'(coefv[k]);
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== e_v || out_result !== e_data[15:0] ||
            out_syndrome !== e_synd[4:0] || out_err !== e_flag) begin
            errors++;
            $display("FAIL %s actual valid=%0b data=%h synd=%0d err=%0b expected valid=%0b data=%h synd=%0d err=%0b",
                     e_tag, out_valid, out_result, out_syndrome, out_err,
                     e_v, e_data[15:0], e_synd, e_flag);
        end
    endtask

    // One clock: check outputs, advance the model, drive new inputs.
    // m is the fault mask for the sample offered in this call.
    task automatic cyc(input bit v, input int x, input logic [20:0] m, input string tag);
        int d;
        int s;
        @(negedge clk);
        check_out();
        if (s1_v) begin
            ref_decode(ref_encode(s1_y[15:0]) ^ next_mask, d, s);
            e_v = 1; e_data = d; e_synd = s; e_flag = (s != 0); e_tag = s1_tag;
        end else begin
            e_v = 0; e_tag = "R5";
        end
        inj_mask = next_mask;
        next_mask = m;
        for (int k = 0; k < 4; k++) coef[k*16 +: 16] = coefv[k][15:0];
        if (v) begin
            hist.push_front(x);
            if (hist.size() > 4) void'(hist.pop_back());
            s1_y = model_fir(); s1_v = 1; s1_tag = tag;
        end else begin
            s1_v = 0;
        end
        in_valid = v;
        in_sample = x[15:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; inj_mask = '0; next_mask = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_result !== 0 || out_syndrome !== 0 || out_err !== 0) begin
            errors++;
            $display("FAIL R1 actual valid=%0b data=%h synd=%0d err=%0b expected all zero",
                     out_valid, out_result, out_syndrome, out_err);
        end
        rst_n = 1;
        hist.delete();
        s1_v = 0; e_v = 0; e_data = 0; e_synd = 0; e_flag = 0; e_tag = "R1";
    endtask

    task automatic set_coef(input int c0, input int c1, input int c2, input int c3);
        coefv[0] = c0; coefv[1] = c1; coefv[2] = c2; coefv[3] = c3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first sample sees zero history
        set_coef(1, 2, 3, 4);
        cyc(1, 100, '0, "R1");
        // R2: impulse response and gaps that must not shift history
        cyc(1, 1000, '0, "R2");
        cyc(0, 7, '0, "R5");
        cyc(1, 0, '0, "R2");
        cyc(0, 9, '0, "R5");
        cyc(0, 9, '0, "R5");
        cyc(1, 0, '0, "R2");
        cyc(1, 0, '0, "R2");
        cyc(1, -3, '0, "R2");
        // R7: mixed samples, negative coefficients, no fault
        set_coef(-1200, 350, 77, -9);
        for (int i = 0; i < 20; i++) cyc(1, rnd16() / 16, '0, "R7");
        // R4: alternating strobe
        for (int i = 0; i < 10; i++) cyc(i % 2, rnd16() / 8, '0, "R4");
        // R3: clamp at both ends
        set_coef(32767, 32767, 32767, 32767);
        for (int i = 0; i < 4; i++) cyc(1, 32767, '0, "R3");
        for (int i = 0; i < 4; i++) cyc(1, -32768, '0, "R3");
        set_coef(-32768, -32768, -32768, -32768);
        for (int i = 0; i < 3; i++) cyc(1, -32768, '0, "R3");
        // R8: single flip at every position, back to back, often clamped
        set_coef(20000, -20000, 20000, 5);
        for (int p = 1; p <= 21; p++)
            cyc(1, (p % 2 == 0) ? 30000 : -30000 + p, 21'(1) << (p - 1), "R8");
        set_coef(3, -2, 1, 1);
        cyc(1, 1234, 21'(1) << 13, "R8");
        // R6: two data flips that land on a third data position
        cyc(1, 555, (21'(1) << 2) | (21'(1) << 4), "R6");
        cyc(1, -4321, (21'(1) << 0) | (21'(1) << 1), "R6");
        // R9: syndrome outside the codeword
        cyc(1, 2222, (21'(1) << 20) | (21'(1) << 2), "R9");
        cyc(1, -777, (21'(1) << 15) | (21'(1) << 14), "R9");
        // R10: double fault miscorrected into position 20
        cyc(1, 4096, (21'(1) << 0) | (21'(1) << 20), "R10");
        cyc(1, 99, (21'(1) << 6) | (21'(1) << 9) | (21'(1) << 11), "R10");
        // R5: idle cycles after faulty words
        for (int i = 0; i < 3; i++) cyc(0, 11, '1, "R5");
        // R1: reset mid-stream clears history
        set_coef(10, 10, 10, 10);
        for (int i = 0; i < 3; i++) cyc(1, 500, '0, "R2");
        do_reset();
        cyc(1, 500, '0, "R1");
        for (int i = 0; i < 4; i++) cyc(0, 0, '0, "R5");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule